// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Access Sequencer

This block gives a local-bus agent access to an external byte-wide nonvolatile memory through one 32-bit control/status word. The agent never drives memory pins directly. It writes a sequence of register words, and each word carries a 3-bit command in bits 31:29 and an 8-bit operand in bits 23:16. The first two commands set the low and then the high half of a 16-bit memory address. The third command starts either a single byte write, using the operand as the data byte, or a single byte read.

Bit 31 works in both directions. On a write it is the strobe that makes a command take effect. On a read it shows whether an access is still running. While that flag is set, the block drives the external memory with a held address and one strobe. When the access ends, the flag clears. After a read, the fetched byte appears in bits 23:16 of the status word.

Software must poll bit 31 until it reads 0 before it issues the next step. The block ignores any command that arrives while the flag is set. The address halves stay latched until they are written again, so repeated accesses to the same location need only the final command.

Top module: `nv_byte_seq`

## Requirements
- R1: After reset, `regRdData` is all zeros, `memAddr` is 0, and `memWrStb` and `memRdStb` are low.
- R2: A register write with bits 31:29 = 100 copies bits 23:16 into `memAddr[7:0]` on the next cycle. A register write with bits 31:29 = 101 copies bits 23:16 into `memAddr[15:8]` on the next cycle. Both take effect only while idle.
- R3: A register write with bit 31 = 0 has no effect on the address, the port byte or the memory strobes.
- R4: A register write with bits 31:29 = 110 starts a write access. `memWrData` shows bits 23:16 of that word, and `memWrStb` stays high for exactly ACCESS_CYCLES cycles starting on the next cycle.
- R5: A register write with bits 31:29 = 111 starts a read access. `memRdStb` stays high for exactly ACCESS_CYCLES cycles. `memRdData` is sampled in the last of those cycles and appears in `regRdData[23:16]` in the cycle the busy flag clears.
- R6: `regRdData[31]` reads 1 for exactly ACCESS_CYCLES cycles, starting the cycle after an accepted start. In the status word, every bit other than 31 and 23:16 reads 0.
- R7: A register write that arrives while `regRdData[31]` is 1 is ignored: it changes neither the address nor the port byte, and it starts no access.
- R8: `memAddr` holds its value across accesses until an address command rewrites it. It is stable for the whole of an access.
- R9: After a write access starts, `regRdData[23:16]` shows the data byte of that write until a later read completes.
- R10: `memWrStb` and `memRdStb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per word |
| regWrData | input | 32 | Register write word: command in bits 31:29, operand in bits 23:16 |
| regRdData | output | 32 | Status word: busy flag in bit 31, port byte in bits 23:16 |
| memAddr | output | 16 | Latched external memory address |
| memWrData | output | 8 | Byte driven to memory on a write |
| memWrStb | output | 1 | High while a write access runs |
| memRdStb | output | 1 | High while a read access runs |
| memRdData | input | 8 | Byte returned by the memory |

## Verification
The bench sweeps a set of addresses whose low and high bytes differ, so a swapped or unlatched half of the address shows as a wrong `memAddr`. Each address gets a write with a distinct byte, then a read. The bench's memory model returns a byte computed from the address, so a read sampled at the wrong moment or from a stale address shows up as a wrong port value. The bench also issues words with bit 31 clear, and commands during a busy window, to separate ignored steps from accepted ones. It repeats reads without reloading the address to confirm that the latched halves persist.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  // command field bits 30:29 when bit 31 is set
  typedef enum logic [1:0] {
    OP_LO_ADDR = 2'b00,
    OP_HI_ADDR = 2'b01,
    OP_WRITE   = 2'b10,
    OP_READ    = 2'b11
  } nvOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic loadData;
    logic captureRd;
  } nvStrobes_t;
endpackage

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int ACCESS_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       cmd,
  output nvStrobes_t       stb,
  output logic             busy,
  output logic             memWrStb,
  output logic             memRdStb
);
  localparam int CW = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(ACCESS_CYCLES);

  logic [CW-1:0] remain;
  logic          isRead;
  logic          accept;
  nvOp_e         op;

  assign op     = nvOp_e'(cmd[1:0]);
  assign busy   = (remain != '0);
  assign accept = regWrEn && cmd[2] && !busy;

  always_comb begin
    stb.loadLo    = accept && (op == OP_LO_ADDR);
    stb.loadHi    = accept && (op == OP_HI_ADDR);
    stb.loadData  = accept && (op == OP_WRITE);
    stb.captureRd = isRead && (remain == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      isRead <= 1'b0;
    end else if (accept && cmd[1]) begin
      remain <= LOAD_VAL;
      isRead <= (op == OP_READ);
    end else if (busy) begin
      remain <= remain - CW'(1);
    end
  end

  assign memWrStb = busy && !isRead;
  assign memRdStb = busy && isRead;
endmodule

// File: rtl/nvseq_dpath.sv
module nvseq_dpath
  import nvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  nvStrobes_t stb,
  input  logic [7:0] operand,
  input  logic [7:0] memRdData,
  output logic [15:0] memAddr,
  output logic [7:0]  portByte
);
  logic [7:0] addrLo;
  logic [7:0] addrHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo   <= '0;
      addrHi   <= '0;
      portByte <= '0;
    end else begin
      if (stb.loadLo)    addrLo   <= operand;
      if (stb.loadHi)    addrHi   <= operand;
      if (stb.loadData)  portByte <= operand;
      else if (stb.captureRd) portByte <= memRdData;
    end
  end

  assign memAddr = {addrHi, addrLo};
endmodule

// File: rtl/nv_byte_seq.sv
module nv_byte_seq
  import nvseq_pkg::*;
#(
  parameter int ACCESS_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [15:0] memAddr,
  output logic [7:0]  memWrData,
  output logic        memWrStb,
  output logic        memRdStb,
  input  logic [7:0]  memRdData
);
  nvStrobes_t stb;
  logic       busy;
  logic [7:0] portByte;

  nvseq_ctrl #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .cmd(regWrData[31:29]),
    .stb(stb), .busy(busy), .memWrStb(memWrStb), .memRdStb(memRdStb)
  );

  nvseq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .operand(regWrData[23:16]),
    .memRdData(memRdData), .memAddr(memAddr), .portByte(portByte)
  );

  assign memWrData = portByte;
  assign regRdData = {busy, 7'b0, portByte, 16'b0};
endmodule

// File: rtl/nvseq_chk.sv
module nvseq_chk #(
  parameter int ACCESS_CYCLES = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic [15:0] memAddr,
  input logic [7:0]  memWrData,
  input logic        memWrStb,
  input logic        memRdStb,
  input logic [7:0]  memRdData
);
  logic        busyNow;
  logic [15:0] runLen;
  assign busyNow = regRdData[31];

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (busyNow) runLen <= runLen + 16'd1;
    else runLen <= '0;
  end

  // R10
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrStb && memRdStb));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[31] && regWrData[30] && !busyNow) |=> busyNow);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyNow |-> (runLen < 16'(ACCESS_CYCLES)));

  // R6
  busy_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyNow && runLen != 16'd0) |-> (runLen == 16'(ACCESS_CYCLES)));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyNow && regWrEn) |=> ($stable(memAddr) && $stable(regRdData[23:16])));

  // R5
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdStb && runLen == 16'(ACCESS_CYCLES - 1)) |=> (regRdData[23:16] == $past(memRdData)));

  // R3
  inactive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[31] && !busyNow) |=> ($stable(memAddr) && !busyNow));
endmodule

bind nv_byte_seq nvseq_chk #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .memAddr(memAddr), .memWrData(memWrData),
  .memWrStb(memWrStb), .memRdStb(memRdStb), .memRdData(memRdData)
);

// File: tb/sim_nv_byte_seq.sv
`timescale 1ns/1ps
module sim_nv_byte_seq;
  localparam int ACC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic        memWrStb;
  logic        memRdStb;
  logic [7:0]  memRdData;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  // memory model: byte is a function of the address
  assign memRdData = memAddr[7:0] ^ memAddr[15:8] ^ 8'h5A;

  nv_byte_seq #(.ACCESS_CYCLES(ACC)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .memAddr(memAddr), .memWrData(memWrData),
    .memWrStb(memWrStb), .memRdStb(memRdStb), .memRdData(memRdData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] cmd, input logic [7:0] val);
    regWrEn   = 1'b1;
    regWrData = {cmd, 5'b0, val, 16'h00FF};
    @(negedge clk);
    regWrEn   = 1'b0;
    regWrData = '0;
  endtask

  // count busy cycles from the current negedge, checking the strobe each cycle
  task automatic wait_idle(input bit isRd, output int n);
    n = 0;
    while (regRdData[31] && n < 100) begin
      if (isRd) check(memRdStb && !memWrStb, "R5", {30'b0, memWrStb, memRdStb}, 32'h1);
      else      check(memWrStb && !memRdStb, "R4", {30'b0, memWrStb, memRdStb}, 32'h2);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] a;
    logic [7:0] wb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(regRdData == 32'h0, "R1", regRdData, 32'h0);
    check(memAddr == 16'h0 && !memWrStb && !memRdStb, "R1", {memAddr, 14'b0, memWrStb, memRdStb}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      a  = 16'h1234 * (i + 1) ^ 16'hA5C3;
      wb = 8'(8'h3C + i * 29);
      put(3'b100, a[7:0]);
      put(3'b101, a[15:8]);
      // R2
      check(memAddr == a, "R2", {16'b0, memAddr}, {16'b0, a});
      put(3'b110, wb);
      // R4
      check(memWrData == wb, "R4", {24'b0, memWrData}, {24'b0, wb});
      wait_idle(1'b0, n);
      // R6
      check(n == ACC, "R6", n, ACC);
      // R9
      check(regRdData == {8'h00, wb, 16'h0}, "R9", regRdData, {8'h00, wb, 16'h0});
      // R8 read without reloading address
      put(3'b111, 8'hEE);
      check(memAddr == a, "R8", {16'b0, memAddr}, {16'b0, a});
      wait_idle(1'b1, n);
      check(n == ACC, "R6", n, ACC);
      // R5
      check(regRdData[23:16] == (a[7:0] ^ a[15:8] ^ 8'h5A), "R5",
            {24'b0, regRdData[23:16]}, {24'b0, a[7:0] ^ a[15:8] ^ 8'h5A});
    end

    // R3: bit 31 clear has no effect
    a = memAddr;
    wb = regRdData[23:16];
    put(3'b000, 8'h11);
    put(3'b010, 8'h22);
    put(3'b011, 8'h33);
    check(memAddr == a && regRdData == {8'h00, wb, 16'h0} && !memWrStb && !memRdStb, "R3",
          {memAddr, regRdData[23:16], 6'b0, memWrStb, memRdStb}, {a, wb, 8'h00});

    // R7: commands while busy
    put(3'b110, 8'h77);
    put(3'b100, 8'hC1);
    put(3'b101, 8'hD2);
    put(3'b111, 8'h00);
    wait_idle(1'b0, n);
    check(n == ACC - 3, "R7", n, ACC - 3);
    check(memAddr == a && regRdData[23:16] == 8'h77, "R7",
          {memAddr, regRdData[23:16], 8'h0}, {a, 8'h77, 8'h0});
    @(negedge clk);
    check(!regRdData[31], "R7", {31'b0, regRdData[31]}, 32'h0);

    // R10 check after mixed traffic
    check(!(memWrStb && memRdStb), "R10", {30'b0, memWrStb, memRdStb}, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule